// File: doc/BRIEF.md
# Enhanced Command Register Front End

This block is the register-facing half of a command channel for a DMA-remapping unit. Software first writes a 64-bit second operand. It then writes a command word that carries an 8-bit opcode in its low byte and a 48-bit first operand in its upper bits. The command write launches the command. The block latches both operands and sets an in-progress flag. If the opcode is supported, the block offers the command to an execution backend over a valid/ready handshake and waits for the backend's done pulse and status code.

When the command completes, the block clears the in-progress flag. It stores the status code directly above that flag in a response register. A status of zero means success; any other value means failure. Opcodes that the capability map marks as absent never reach the backend and complete at once with a fixed failure code.

A read-only map of 256 capability bits, one per opcode, is spread over four consecutive 64-bit registers. All registers sit on a simple 64-bit bus whose read data appears one cycle after the read strobe.

Top module: `ecmd_frontend`

## Requirements
- R1: After reset, the command, second-operand and response registers read as zero and `be_valid` is low.
- R2: With the flag clear, a write to offset 0x400 launches a command. Opcode = write data [7:0], first operand = write data [63:16], and bits [15:8] are dropped. From the next cycle, 0x400 reads back opcode and first operand at those positions, the response bit 0 (in-progress) reads 1, and `be_opcode`/`be_opa` carry the fields.
- R3: `be_valid` rises the cycle after a launch of a supported opcode. It stays high with a stable opcode and operands until the cycle `be_ready` is high, and is low afterwards.
- R4: After the backend has accepted a command, the clock edge that samples `be_done` high clears the in-progress flag and loads `be_status` into response bits [7:1].
- R5: Opcodes whose capability bit is clear never assert `be_valid`. They hold the flag for exactly one cycle and then complete with status 0x7E (response reads 0xFC).
- R6: While the flag is set, writes to 0x400 and 0x408 are ignored. The latched command and operand are unchanged and no new command is issued.
- R7: A write to 0x408 with the flag clear stores the second operand, which reads back at 0x408. It launches nothing and leaves the response unchanged. The stored value drives `be_opb` during the next command.
- R8: Offsets 0x430 + 8k (k = 0..3) read capability word k. Bit n of word k marks opcode 64k+n. Enable, disable, freeze and unfreeze (0xF0, 0xF1, 0xF4, 0xF5) sit at bits 48, 49, 52, 53 of word 3.
- R9: Read data appears the cycle after the read strobe. Undefined or misaligned offsets read zero, and writes to the response and capability registers have no effect.
- R10: A backend status of zero leaves the response register reading exactly zero after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid one cycle after `reg_rd` |
| be_valid | output | 1 | Command offered to the backend |
| be_ready | input | 1 | Backend accepts the offered command |
| be_opcode | output | 8 | Latched opcode |
| be_opa | output | 48 | Latched first operand |
| be_opb | output | 64 | Latched second operand |
| be_done | input | 1 | Backend completion pulse |
| be_status | input | 7 | Backend completion status, 0 = success |

## Verification
The launch path is exercised with four command patterns. A supported opcode meets a backend that stalls `be_ready` for a cycle, which separates a held offer from a one-cycle pulse. An opcode that finishes with a nonzero status shows the code landing above the flag rather than in it. An unsupported opcode separates the local short-cut completion from backend traffic. A launch with `be_ready` already high shows whether acceptance happens on the first offered cycle. Writes issued while a command is in flight, and writes to read-only or undefined offsets, are followed by read-backs that show whether any latched state moved.

// File: rtl/ecmd_pkg.sv
package ecmd_pkg;
  localparam int DATA_W  = 64;
  localparam int OPC_W   = 8;
  localparam int OPA_LSB = 16;
  localparam int OPA_W   = DATA_W - OPA_LSB;
  localparam int STAT_W  = 7;
  localparam int NUM_OPC = 1 << OPC_W;
  localparam int CAP_WORDS = NUM_OPC / DATA_W;
  localparam int CAP_SEL_W = $clog2(CAP_WORDS);

  localparam int OFS_CMD  = 'h400;
  localparam int OFS_OPB  = 'h408;
  localparam int OFS_RESP = 'h410;
  localparam int OFS_CAP  = 'h430;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_UNSUP = 2'd3
  } ecmd_state_e;

  typedef struct packed {
    logic [OPA_W-1:0] opa;
    logic [OPC_W-1:0] opcode;
  } ecmd_cmd_t;
endpackage

// File: rtl/ecmd_rst_sync.sv
module ecmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecmd_cap_map.sv
module ecmd_cap_map
  import ecmd_pkg::*;
#(
  parameter logic [NUM_OPC-1:0] CAP_MAP = '0
) (
  input  logic [OPC_W-1:0]     lookup_opcode,
  output logic                 lookup_hit,
  input  logic [CAP_SEL_W-1:0] word_sel,
  output logic [DATA_W-1:0]    word_data
);
  logic [DATA_W-1:0] words [CAP_WORDS];

  for (genvar k = 0; k < CAP_WORDS; k++) begin : g_word
    assign words[k] = CAP_MAP[k*DATA_W +: DATA_W];
  end

  assign lookup_hit = CAP_MAP[lookup_opcode];
  assign word_data  = words[word_sel];
endmodule

// File: rtl/ecmd_launch_ctrl.sv
module ecmd_launch_ctrl
  import ecmd_pkg::*;
#(
  parameter logic [STAT_W-1:0] UNSUP_CODE = 7'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              opb_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              opc_supported,
  input  logic              be_ready,
  input  logic              be_done,
  input  logic [STAT_W-1:0] be_status,
  output logic              busy,
  output logic              be_valid,
  output ecmd_cmd_t         cmd_q,
  output logic [DATA_W-1:0] opb_q,
  output logic [STAT_W-1:0] status_q
);
  ecmd_state_e       state_q, state_d;
  ecmd_cmd_t         cmd_d;
  logic [STAT_W-1:0] status_d;
  logic              cmd_en, opb_en, status_en;

  assign cmd_en = cmd_wr && (state_q == ST_IDLE);
  assign opb_en = opb_wr && (state_q == ST_IDLE);

  always_comb begin
    state_d   = state_q;
    status_d  = status_q;
    status_en = 1'b0;
    cmd_d.opcode = wdata[OPC_W-1:0];
    cmd_d.opa    = wdata[DATA_W-1:OPA_LSB];
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) state_d = opc_supported ? ST_ISSUE : ST_UNSUP;
      end
      ST_ISSUE: begin
        if (be_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (be_done) begin
          state_d   = ST_IDLE;
          status_d  = be_status;
          status_en = 1'b1;
        end
      end
      ST_UNSUP: begin
        state_d   = ST_IDLE;
        status_d  = UNSUP_CODE;
        status_en = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= '0;
      opb_q    <= '0;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_en)    cmd_q    <= cmd_d;
      if (opb_en)    opb_q    <= wdata;
      if (status_en) status_q <= status_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign be_valid = (state_q == ST_ISSUE);
endmodule

// File: rtl/ecmd_read_mux.sv
module ecmd_read_mux
  import ecmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  ecmd_cmd_t            cmd_q,
  input  logic [DATA_W-1:0]    opb_q,
  input  logic [STAT_W-1:0]    status_q,
  input  logic                 busy,
  input  logic [DATA_W-1:0]    cap_word,
  output logic [CAP_SEL_W-1:0] cap_sel,
  output logic [DATA_W-1:0]    rdata
);
  localparam int CAP_SPAN = CAP_WORDS * 8;

  logic [ADDR_W-1:0] cap_off;
  logic              hit_cap;
  logic [DATA_W-1:0] rdata_d;

  assign cap_off = addr - ADDR_W'(OFS_CAP);
  assign hit_cap = (int'(cap_off) < CAP_SPAN) && (cap_off[2:0] == 3'b000);
  assign cap_sel = cap_off[3 +: CAP_SEL_W];

  always_comb begin
    rdata_d = '0;
    if (addr == ADDR_W'(OFS_CMD)) begin
      rdata_d = {cmd_q.opa, {(OPA_LSB-OPC_W){1'b0}}, cmd_q.opcode};
    end else if (addr == ADDR_W'(OFS_OPB)) begin
      rdata_d = opb_q;
    end else if (addr == ADDR_W'(OFS_RESP)) begin
      rdata_d = {{(DATA_W-STAT_W-1){1'b0}}, status_q, busy};
    end else if (hit_cap) begin
      rdata_d = cap_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      if (rd_en) rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/ecmd_frontend.sv
module ecmd_frontend
  import ecmd_pkg::*;
#(
  parameter int                 ADDR_W     = 12,
  parameter logic [STAT_W-1:0]  UNSUP_CODE = 7'h7E,
  parameter logic [NUM_OPC-1:0] CAP_MAP    = (256'd1 << 240) | (256'd1 << 241) |
                                             (256'd1 << 244) | (256'd1 << 245) |
                                             (256'd1 << 64)  | 256'hE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              be_valid,
  input  logic              be_ready,
  output logic [OPC_W-1:0]  be_opcode,
  output logic [OPA_W-1:0]  be_opa,
  output logic [DATA_W-1:0] be_opb,
  input  logic              be_done,
  input  logic [STAT_W-1:0] be_status
);
  logic                 rst_sync_n;
  logic                 cmd_wr, opb_wr;
  logic                 opc_hit, busy;
  logic [CAP_SEL_W-1:0] cap_sel;
  logic [DATA_W-1:0]    cap_word;
  ecmd_cmd_t            cmd_q;
  logic [DATA_W-1:0]    opb_q;
  logic [STAT_W-1:0]    status_q;

  assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
  assign opb_wr = reg_wr && (reg_addr == ADDR_W'(OFS_OPB));

  ecmd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ecmd_cap_map #(.CAP_MAP(CAP_MAP)) u_cap (
    .lookup_opcode (reg_wdata[OPC_W-1:0]),
    .lookup_hit    (opc_hit),
    .word_sel      (cap_sel),
    .word_data     (cap_word)
  );

  ecmd_launch_ctrl #(.UNSUP_CODE(UNSUP_CODE)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cmd_wr        (cmd_wr),
    .opb_wr        (opb_wr),
    .wdata         (reg_wdata),
    .opc_supported (opc_hit),
    .be_ready      (be_ready),
    .be_done       (be_done),
    .be_status     (be_status),
    .busy          (busy),
    .be_valid      (be_valid),
    .cmd_q         (cmd_q),
    .opb_q         (opb_q),
    .status_q      (status_q)
  );

  ecmd_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .cmd_q    (cmd_q),
    .opb_q    (opb_q),
    .status_q (status_q),
    .busy     (busy),
    .cap_word (cap_word),
    .cap_sel  (cap_sel),
    .rdata    (reg_rdata)
  );

  assign be_opcode = cmd_q.opcode;
  assign be_opa    = cmd_q.opa;
  assign be_opb    = opb_q;
endmodule

// File: rtl/ecmd_frontend_chk.sv
module ecmd_frontend_chk
  import ecmd_pkg::*;
#(
  parameter int                 ADDR_W  = 12,
  parameter logic [NUM_OPC-1:0] CAP_MAP = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              be_valid,
  input logic              be_ready,
  input logic [OPC_W-1:0]  be_opcode,
  input logic [OPA_W-1:0]  be_opa,
  input logic [DATA_W-1:0] be_opb,
  input logic              be_done,
  input logic [1:0]        state,
  input logic              busy
);
  logic              cmd_wr_c;
  logic              undef_c;
  logic [ADDR_W-1:0] cap_off_c;

  assign cmd_wr_c  = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
  assign cap_off_c = reg_addr - ADDR_W'(OFS_CAP);
  assign undef_c   = (reg_addr != ADDR_W'(OFS_CMD)) && (reg_addr != ADDR_W'(OFS_OPB)) &&
                     (reg_addr != ADDR_W'(OFS_RESP)) &&
                     !((int'(cap_off_c) < CAP_WORDS*8) && (cap_off_c[2:0] == 3'b000));

  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_c && !busy) |=> busy);

  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && !be_ready) |=> (be_valid && $stable(be_opcode) && $stable(be_opa) && $stable(be_opb)));

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && be_done) |=> !busy);

  p_no_unsup_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid |-> CAP_MAP[be_opcode]);

  p_unsup_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNSUP) |=> !busy);

  p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> ($stable(be_opcode) && $stable(be_opa) && $stable(be_opb)));

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && undef_c) |=> (reg_rdata == '0));
endmodule

bind ecmd_frontend ecmd_frontend_chk #(.ADDR_W(ADDR_W), .CAP_MAP(CAP_MAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .be_valid  (be_valid),
  .be_ready  (be_ready),
  .be_opcode (be_opcode),
  .be_opa    (be_opa),
  .be_opb    (be_opb),
  .be_done   (be_done),
  .state     (u_ctrl.state_q),
  .busy      (busy)
);

// File: tb/ecmd_frontend_tb.sv
module ecmd_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_wr, reg_rd;
  logic [63:0] reg_wdata, reg_rdata;
  logic        be_valid, be_ready, be_done;
  logic [7:0]  be_opcode;
  logic [47:0] be_opa;
  logic [63:0] be_opb;
  logic [6:0]  be_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic        rd_d = 1'b0;

  always #5 clk = ~clk;

  ecmd_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .be_valid(be_valid), .be_ready(be_ready),
    .be_opcode(be_opcode), .be_opa(be_opa), .be_opb(be_opb), .be_done(be_done),
    .be_status(be_status)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read data", reg_rdata, 64'hx);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [63:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    tick();
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    be_ready = 1'b0; be_done = 1'b0; be_status = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    check("R1 be_valid after reset", 64'(be_valid), 64'd0);
    bus_read(12'h400, 64'd0, "R1 command reg reset");
    bus_read(12'h408, 64'd0, "R1 operand reg reset");
    bus_read(12'h410, 64'd0, "R1 response reg reset");

    // R8 capability words
    bus_read(12'h430, 64'h0000_0000_0000_000E, "R8 cap word 0");
    bus_read(12'h438, 64'h0000_0000_0000_0001, "R8 cap word 1");
    bus_read(12'h440, 64'h0, "R8 cap word 2");
    bus_read(12'h448, 64'h0033_0000_0000_0000, "R8 cap word 3 enable/disable/freeze/unfreeze");

    // R9 read-only and undefined offsets
    bus_write(12'h438, '1);
    bus_write(12'h410, 64'hFF);
    bus_read(12'h438, 64'h1, "R9 cap word write ignored");
    bus_read(12'h410, 64'h0, "R9 response write ignored");
    bus_read(12'h418, 64'h0, "R9 undefined offset");
    bus_read(12'h450, 64'h0, "R9 past cap region");
    bus_read(12'h434, 64'h0, "R9 misaligned cap offset");

    // R7 second operand write
    bus_write(12'h408, 64'hDEAD_BEEF_CAFE_0123);
    check("R7 no launch from operand write", 64'(be_valid), 64'd0);
    bus_read(12'h408, 64'hDEAD_BEEF_CAFE_0123, "R7 operand readback");
    bus_read(12'h410, 64'h0, "R7 response untouched");

    // R2/R3/R10 supported opcode, backend stalls one cycle
    bus_write(12'h400, {48'h1234_5678_9ABC, 8'hFF, 8'h02});
    check("R3 valid after launch", 64'(be_valid), 64'd1);
    check("R2 opcode to backend", 64'(be_opcode), 64'h02);
    check("R2 operand A to backend", 64'(be_opa), 64'h1234_5678_9ABC);
    check("R7 operand B to backend", be_opb, 64'hDEAD_BEEF_CAFE_0123);
    tick();
    check("R3 valid held while not ready", 64'(be_valid), 64'd1);
    be_ready = 1'b1;
    tick();
    be_ready = 1'b0;
    check("R3 valid drops after accept", 64'(be_valid), 64'd0);
    bus_read(12'h410, 64'h1, "R2 in-progress bit set");
    be_done = 1'b1; be_status = 7'h00;
    tick();
    be_done = 1'b0;
    bus_read(12'h410, 64'h0, "R10 success status reads zero");
    bus_read(12'h400, {48'h1234_5678_9ABC, 8'h00, 8'h02}, "R2 command readback");

    // R4/R6 failing status, writes while busy
    bus_write(12'h400, {48'h5, 8'h00, 8'hF4});
    check("R2 freeze opcode offered", 64'(be_opcode), 64'hF4);
    be_ready = 1'b1;
    tick();
    be_ready = 1'b0;
    bus_write(12'h400, 64'h0000_0000_0000_0003);
    check("R6 no offer from busy write", 64'(be_valid), 64'd0);
    bus_write(12'h408, 64'h1111);
    be_done = 1'b1; be_status = 7'h15;
    tick();
    be_done = 1'b0;
    bus_read(12'h410, 64'h2A, "R4 status above flag");
    bus_read(12'h400, {48'h5, 8'h00, 8'hF4}, "R6 command kept");
    bus_read(12'h408, 64'hDEAD_BEEF_CAFE_0123, "R6 operand kept");

    // R5 unsupported opcode
    bus_write(12'h400, 64'h10);
    check("R5 no offer for unsupported", 64'(be_valid), 64'd0);
    bus_read(12'h410, 64'h2B, "R5 flag set one cycle");
    check("R5 still no offer", 64'(be_valid), 64'd0);
    bus_read(12'h410, 64'hFC, "R5 unsupported status");
    bus_read(12'h400, 64'h10, "R5 command latched");

    // R3/R7 ready already high
    bus_write(12'h408, 64'h0BAD_F00D);
    be_ready = 1'b1;
    bus_write(12'h400, {48'h7, 8'h00, 8'hF0});
    check("R3 offer with ready high", 64'(be_valid), 64'd1);
    check("R7 new operand B", be_opb, 64'h0BAD_F00D);
    tick();
    be_ready = 1'b0;
    check("R3 accepted in one cycle", 64'(be_valid), 64'd0);
    be_done = 1'b1; be_status = 7'h00;
    tick();
    be_done = 1'b0;
    bus_read(12'h410, 64'h0, "R10 success after enable");

    repeat (3) tick();
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule